// File: doc/BRIEF.md
# Backplane Link Transceiver Direction Controller

This block decides, cycle by cycle, whether a plug-in module drives or listens on the two differential pairs of its backplane serial link: the data pair and the clock pair. In the normal synchronous mode the link is half duplex, and the side that transmits also sources the clock, so both pairs turn around together. In the full-duplex asynchronous test mode, outgoing data leaves on the clock pair and incoming data arrives on the data pair, so the data pair is never driven.

The local processor requests transmission with an active-low transmit request. It ends a transmission with a one-cycle done pulse, and it selects the mode with a level request. A failsafe input turns every driver off at once. The backplane side supplies a select and a reset line. The block returns a presence indication, a module reset request and a gated sync strobe. An active-low transmitter-active flag, meant for an open-collector output stage, reports when the module is driving the link.

Top module: `link_dir_ctrl`

## Requirements
- R1: In synchronous mode (`async_mode` = 0), `data_drv_en` and `clk_drv_en` are always equal. From idle, with `failsafe` low, a low `tx_req_n` raises both of them in the cycle after the clock edge that samples it.
- R2: In asynchronous mode (`async_mode` = 1), `data_drv_en` stays 0. A transmission raises only `clk_drv_en`, with the same timing as R1.
- R3: While `failsafe` is high, `data_drv_en` and `clk_drv_en` are 0 in that same cycle, in either mode. A transmission cut off by `failsafe` does not resume until `tx_req_n` has gone high and then low again.
- R4: While `tx_req_n` stays high, the block never enables a driver.
- R5: A `tx_done` pulse clears both driver enables in the cycle it is high. The drivers stay off after that, even if `tx_req_n` is held low, until `tx_req_n` returns high and is lowered again.
- R6: `async_mode` takes the value of `async_req` at a clock edge only when no transmission is in progress at that edge. A request that arrives during a transmission takes effect at the first edge after it ends, and `async_mode` stays constant while a driver is enabled.
- R7: `tx_active_n` is 0 exactly when the module is transmitting, meaning `clk_drv_en` is 1.
- R8: `mod_reset_req` is 1 in the cycle after an edge at which `bp_select` and `bp_reset` are both 1. Otherwise it is 0.
- R9: `present` equals `bp_select` in every cycle.
- R10: `sync_out` is 1 in the cycle after an edge at which `sync_en` and `sync_pulse` are both 1. Otherwise it is 0.
- R11: After reset the block is idle in synchronous mode, with every driver enable, `mod_reset_req` and `sync_out` at 0 and `tx_active_n` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req_n | input | 1 | Processor transmit request, active low |
| async_req | input | 1 | Requested mode: 1 asynchronous, 0 synchronous |
| tx_done | input | 1 | One-cycle pulse after the last character has been sent |
| failsafe | input | 1 | Forces every transceiver to receive |
| bp_select | input | 1 | Backplane select, active high |
| bp_reset | input | 1 | Backplane reset, active high |
| sync_en | input | 1 | Host permission for the sync strobe |
| sync_pulse | input | 1 | Locally generated sync event |
| data_drv_en | output | 1 | Data pair driver enable |
| clk_drv_en | output | 1 | Clock pair driver enable |
| tx_active_n | output | 1 | Transmitter-active flag, active low |
| async_mode | output | 1 | Mode in effect: 1 asynchronous |
| mod_reset_req | output | 1 | Module hardware reset request |
| present | output | 1 | Presence indication |
| sync_out | output | 1 | Gated sync strobe |

## Verification
The bench targets the turnarounds in which a wrong design ends up driving the bus. If `tx_done` or `failsafe` were handled one cycle late, the pairs would stay driven for an extra cycle after the last character. If the done pulse did not re-arm the request, transmission would restart while the request is still held low. The bench also issues mode requests in the middle of a transmission. An arbiter that applied them at once would swap the roles of the pairs while they are being driven and could leave the data pair driven in test mode. A long pseudo-random sweep, compared cycle by cycle against an arithmetic model, also covers the reset request and the sync strobe gating. An error in either would produce spurious resets or strobes the host never allowed.

// File: rtl/link_dir_pkg.sv
package link_dir_pkg;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_ACTIVE = 2'd1,
        TX_HOLD   = 2'd2
    } tx_state_e;

    typedef enum logic {
        MODE_SYNC  = 1'b0,
        MODE_ASYNC = 1'b1
    } link_mode_e;

    typedef struct packed {
        tx_state_e st;
    } tx_regs_t;

    typedef struct packed {
        link_mode_e mode;
    } mode_regs_t;

    typedef struct packed {
        logic reset_req;
        logic sync_str;
    } side_regs_t;

endpackage

// File: rtl/link_tx_fsm.sv
module link_tx_fsm
    import link_dir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req_n,
    input  logic tx_done,
    input  logic failsafe,
    output logic tx_on,
    output logic busy
);

    tx_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            TX_IDLE: begin
                if (!tx_req_n && !failsafe) r_d.st = TX_ACTIVE;
            end
            TX_ACTIVE: begin
                if (failsafe || tx_done) begin
                    r_d.st = tx_req_n ? TX_IDLE : TX_HOLD;
                end else if (tx_req_n) begin
                    r_d.st = TX_IDLE;
                end
            end
            TX_HOLD: begin
                if (tx_req_n) r_d.st = TX_IDLE;
            end
            default: r_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: TX_IDLE};
        else        r_q <= r_d;
    end

    // the done pulse and failsafe cut the drivers in the cycle they are seen
    assign busy  = (r_q.st == TX_ACTIVE);
    assign tx_on = busy && !tx_done && !failsafe;

endmodule

// File: rtl/link_mode_arb.sv
module link_mode_arb
    import link_dir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic async_req,
    output logic async_mode
);

    mode_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!busy) r_d.mode = async_req ? MODE_ASYNC : MODE_SYNC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{mode: MODE_SYNC};
        else        r_q <= r_d;
    end

    assign async_mode = (r_q.mode == MODE_ASYNC);

endmodule

// File: rtl/link_pair_steer.sv
module link_pair_steer (
    input  logic tx_on,
    input  logic async_mode,
    input  logic failsafe,
    output logic data_drv_en,
    output logic clk_drv_en,
    output logic tx_active_n
);

    logic drive;

    always_comb begin
        drive       = tx_on && !failsafe;
        clk_drv_en  = drive;
        data_drv_en = drive && !async_mode;
        tx_active_n = !drive;
    end

endmodule

// File: rtl/link_side_sigs.sv
module link_side_sigs
    import link_dir_pkg::*;
#(
    parameter bit REG_SIDE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bp_select,
    input  logic bp_reset,
    input  logic sync_en,
    input  logic sync_pulse,
    output logic present,
    output logic mod_reset_req,
    output logic sync_out
);

    assign present = bp_select;

    generate
        if (REG_SIDE) begin : g_reg
            side_regs_t r_d, r_q;

            always_comb begin
                r_d           = r_q;
                r_d.reset_req = bp_select && bp_reset;
                r_d.sync_str  = sync_en && sync_pulse;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= '{reset_req: 1'b0, sync_str: 1'b0};
                else        r_q <= r_d;
            end

            assign mod_reset_req = r_q.reset_req;
            assign sync_out      = r_q.sync_str;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk    = clk ^ rst_n;
            assign mod_reset_req = bp_select && bp_reset;
            assign sync_out      = sync_en && sync_pulse;
        end
    endgenerate

endmodule

// File: rtl/link_dir_ctrl.sv
module link_dir_ctrl #(
    parameter bit REG_SIDE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req_n,
    input  logic async_req,
    input  logic tx_done,
    input  logic failsafe,
    input  logic bp_select,
    input  logic bp_reset,
    input  logic sync_en,
    input  logic sync_pulse,
    output logic data_drv_en,
    output logic clk_drv_en,
    output logic tx_active_n,
    output logic async_mode,
    output logic mod_reset_req,
    output logic present,
    output logic sync_out
);

    logic tx_on;
    logic busy;

    link_tx_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_req_n (tx_req_n),
        .tx_done  (tx_done),
        .failsafe (failsafe),
        .tx_on    (tx_on),
        .busy     (busy)
    );

    link_mode_arb u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .async_req  (async_req),
        .async_mode (async_mode)
    );

    link_pair_steer u_steer (
        .tx_on       (tx_on),
        .async_mode  (async_mode),
        .failsafe    (failsafe),
        .data_drv_en (data_drv_en),
        .clk_drv_en  (clk_drv_en),
        .tx_active_n (tx_active_n)
    );

    link_side_sigs #(.REG_SIDE(REG_SIDE)) u_side (
        .clk           (clk),
        .rst_n         (rst_n),
        .bp_select     (bp_select),
        .bp_reset      (bp_reset),
        .sync_en       (sync_en),
        .sync_pulse    (sync_pulse),
        .present       (present),
        .mod_reset_req (mod_reset_req),
        .sync_out      (sync_out)
    );

endmodule

// File: rtl/link_dir_ctrl_chk.sv
module link_dir_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_req_n,
    input logic tx_done,
    input logic failsafe,
    input logic bp_select,
    input logic bp_reset,
    input logic sync_en,
    input logic sync_pulse,
    input logic data_drv_en,
    input logic clk_drv_en,
    input logic tx_active_n,
    input logic async_mode,
    input logic mod_reset_req,
    input logic present,
    input logic sync_out
);

    // R1
    sync_pairs_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !async_mode |-> (data_drv_en == clk_drv_en));

    // R2
    async_data_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        async_mode |-> !data_drv_en);

    // R3
    failsafe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        failsafe |-> (!data_drv_en && !clk_drv_en));

    // R4
    drive_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_drv_en) |-> $past(!tx_req_n));

    // R5
    done_cuts_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !clk_drv_en);

    // R6
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_drv_en |=> $stable(async_mode));

    // R7
    flag_tracks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active_n != clk_drv_en);

    // R8
    reset_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_select && bp_reset) |=> mod_reset_req);

    // R9
    presence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        present == bp_select);

    // R10
    sync_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> $past(sync_en && sync_pulse));

endmodule

bind link_dir_ctrl link_dir_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_req_n      (tx_req_n),
    .tx_done       (tx_done),
    .failsafe      (failsafe),
    .bp_select     (bp_select),
    .bp_reset      (bp_reset),
    .sync_en       (sync_en),
    .sync_pulse    (sync_pulse),
    .data_drv_en   (data_drv_en),
    .clk_drv_en    (clk_drv_en),
    .tx_active_n   (tx_active_n),
    .async_mode    (async_mode),
    .mod_reset_req (mod_reset_req),
    .present       (present),
    .sync_out      (sync_out)
);

// File: tb/tb_link_dir_ctrl.sv
`timescale 1ns/1ps
module tb_link_dir_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_req_n = 1'b1, async_req = 1'b0, tx_done = 1'b0, failsafe = 1'b0;
    logic bp_select = 1'b0, bp_reset = 1'b0, sync_en = 1'b0, sync_pulse = 1'b0;
    logic data_drv_en, clk_drv_en, tx_active_n, async_mode;
    logic mod_reset_req, present, sync_out;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // reference model state: 0 idle, 1 active, 2 hold
    int  m_st = 0;
    bit  m_mode = 1'b0;
    bit  m_rst = 1'b0;
    bit  m_sync = 1'b0;

    always #2 clk = ~clk;

    link_dir_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tx_req_n(tx_req_n), .async_req(async_req),
        .tx_done(tx_done), .failsafe(failsafe), .bp_select(bp_select),
        .bp_reset(bp_reset), .sync_en(sync_en), .sync_pulse(sync_pulse),
        .data_drv_en(data_drv_en), .clk_drv_en(clk_drv_en),
        .tx_active_n(tx_active_n), .async_mode(async_mode),
        .mod_reset_req(mod_reset_req), .present(present), .sync_out(sync_out)
    );

    task automatic chk(input string tag, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
        end
    endtask

    // inputs are already driven after a falling edge; compare, then advance model
    task automatic step(input string tag);
        bit on;
        #1;
        on = (m_st == 1) && !tx_done && !failsafe;
        if (tag == "SWEEP") begin
            chk("R1", "data_drv_en", data_drv_en, on && !m_mode);
            chk("R2", "clk_drv_en", clk_drv_en, on);
            chk("R7", "tx_active_n", tx_active_n, !on);
            chk("R6", "async_mode", async_mode, m_mode);
            chk("R8", "mod_reset_req", mod_reset_req, m_rst);
            chk("R9", "present", present, bp_select);
            chk("R10", "sync_out", sync_out, m_sync);
        end else begin
            chk(tag, "data_drv_en", data_drv_en, on && !m_mode);
            chk(tag, "clk_drv_en", clk_drv_en, on);
            chk(tag, "tx_active_n", tx_active_n, !on);
            chk(tag, "async_mode", async_mode, m_mode);
        end
        if (m_st != 1) m_mode = async_req;
        case (m_st)
            0: if (!tx_req_n && !failsafe) m_st = 1;
            1: if (failsafe || tx_done) m_st = tx_req_n ? 0 : 2;
               else if (tx_req_n) m_st = 0;
            default: if (tx_req_n) m_st = 0;
        endcase
        m_rst  = bp_select && bp_reset;
        m_sync = sync_en && sync_pulse;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        tx_req_n = 1'b1; tx_done = 1'b0; failsafe = 1'b0;
        bp_select = 1'b0; bp_reset = 1'b0; sync_en = 1'b0; sync_pulse = 1'b0;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        #1;
        chk("R11", "data_drv_en", data_drv_en, 1'b0);
        chk("R11", "clk_drv_en", clk_drv_en, 1'b0);
        chk("R11", "tx_active_n", tx_active_n, 1'b1);
        chk("R11", "async_mode", async_mode, 1'b0);
        chk("R11", "mod_reset_req", mod_reset_req, 1'b0);
        chk("R11", "sync_out", sync_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: no request, no drive
        for (int i = 0; i < 4; i++) step("R4");

        // R1: synchronous transmission, then release
        tx_req_n = 1'b0; step("R1"); step("R1"); step("R1");
        tx_req_n = 1'b1; step("R1"); step("R1");

        // R5: done pulse while request held, then re-arm
        tx_req_n = 1'b0; step("R5"); step("R5");
        tx_done = 1'b1; step("R5");
        tx_done = 1'b0; step("R5"); step("R5");
        tx_req_n = 1'b1; step("R5");
        tx_req_n = 1'b0; step("R5"); step("R5");

        // R6: mode request during a transmission is deferred
        async_req = 1'b1; step("R6"); step("R6");
        tx_done = 1'b1; tx_req_n = 1'b1; step("R6");
        tx_done = 1'b0; step("R6"); step("R6");

        // R2: asynchronous transmission uses the clock pair only
        tx_req_n = 1'b0; step("R2"); step("R2"); step("R2");
        // R3: failsafe cuts drive in the same cycle and blocks resumption
        failsafe = 1'b1; step("R3"); step("R3");
        failsafe = 1'b0; step("R3"); step("R3");
        tx_req_n = 1'b1; step("R3");
        tx_req_n = 1'b0; step("R3"); step("R3");
        async_req = 1'b0; tx_req_n = 1'b1; step("R3"); step("R3");
        tx_req_n = 1'b0; step("R3"); step("R3");
        failsafe = 1'b1; step("R3");
        idle_inputs(); step("R3"); step("R3");

        // near-exhaustive sweep against the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom;
            if ((r & 3) == 0) tx_req_n = ~tx_req_n;
            if (((r >> 2) & 15) == 0) async_req = ~async_req;
            tx_done    = (((r >> 6) & 7) == 0);
            failsafe   = (((r >> 9) & 31) == 0);
            bp_select  = r[14];
            bp_reset   = r[15] & r[16];
            sync_en    = r[17];
            sync_pulse = r[18];
            step("SWEEP");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule